// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns a single host request into the complete pin-level sequence for an 8-bit asynchronous NAND flash device. The host selects one of four operations, supplies a block number and pulses `start`:
- device reset
- identifier read
- status read
- block erase

The sequencer then performs every step of the operation:
- It asserts chip enable.
- It drives command and address bytes with the latch strobes.
- It waits out the command-to-read gap.
- It collects the returned bytes.
- It watches ready/busy under a timeout.

When the operation ends, the sequencer reports the result with a one-cycle `done` pulse.

Reset and erase do not finish when the device becomes ready. After ready/busy releases, the sequencer drops chip enable for a short gap and then reads the status byte on its own. The host therefore receives a single verdict per request: a pass flag, a timeout flag, the 32-bit identifier word and the last status byte. All strobe phases and gaps are counted in clock cycles and set by parameters, so the same logic can be matched to any clock rate and device speed grade.

Top module: `nand_seq`

## Requirements
- R1: Operation code 0 (reset) sends command FFh and waits for ready. It then releases CE and reads status with command 70h. `ok` is 1 exactly when the status byte equals STAT_OK (default C0h) and no timeout occurred.
- R2: Operation code 1 (read ID) sends command 90h and one address byte 00h. After a gap of T_GAP clocks it performs four read cycles, and the first byte read lands in `id_word[31:24]`. `ok` is 1 exactly when `id_word[31:16]` equals ID_EXPECT; the lower 16 bits have no effect on `ok`.
- R3: Operation code 2 (read status) sends command 70h and performs one read cycle after the gap. The byte is returned on `stat_byte`, and `ok` is 1 exactly when bit 0 (fail) of that byte is 0.
- R4: Operation code 3 (erase) sends command 60h, then three address bytes, then command D0h. The address bytes carry the row value `blk << PAGE_BITS`, least significant byte first.
- R5: After D0h, the erase waits T_WB clocks before sampling ready/busy. The status command is issued only after the device is ready and CE has been high for at least T_GAP clocks. `ok` is 1 exactly when status bit 0 is 0.
- R6: When ready/busy stays low for RB_MAX polling clocks, the operation ends with `timeout_err`=1 and `ok`=0, and no status read follows. `timeout_err` is 0 for an operation that completes normally.
- R7: On the bus:
  - CLE and ALE are never high together.
  - WE# and RE# are never low together, and either one is low only while CE# is low.
  - CLE and ALE are stable across each rising edge of WE#.
  - WE# stays low for WE_LO clocks and RE# for RE_LO clocks.
- R8: The IO bus output enable is high only during command and address cycles, and never while RE# is low.
- R9: After reset, `done` is 0 and all strobes are inactive. Each accepted request produces exactly one single-cycle `done` pulse. A `start` raised while an operation is in flight is ignored, and a `start` raised in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when idle |
| op | input | 2 | Operation: 0 reset, 1 read ID, 2 read status, 3 erase |
| blk | input | BLK_W | Block number for erase |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Pass verdict of the last operation |
| timeout_err | output | 1 | Ready/busy wait exceeded RB_MAX |
| id_word | output | 32 | Identifier word, first byte most significant |
| stat_byte | output | 8 | Last status byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from device |
| nand_io_in | input | 8 | Data from device |
| nand_io_out | output | 8 | Data to device |
| nand_io_oe | output | 1 | Output enable for the IO bus |

## Verification
Two things can coincide in one cycle: the `done` pulse of one operation and the `start` of the next. The bench chains every request so that the new `start` is driven in exactly the cycle `done` is seen. Each request must then produce its own complete command log and its own result, with no request lost.

A second case raises `start` with a different operation while an erase is still in flight. This is judged two ways:
- The captured bus log must hold only the erase sequence.
- No extra `done` may appear in the quiet window that follows.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_RESET  = 2'd0,
        OP_READID = 2'd1,
        OP_STATUS = 2'd2,
        OP_ERASE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BC_CMD,
        BC_ADDR,
        BC_READ,
        BC_GAP
    } bus_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_CMD1,
        SQ_ADDR,
        SQ_CMD2,
        SQ_GAP,
        SQ_READ,
        SQ_RB,
        SQ_CEOFF,
        SQ_SCMD,
        SQ_SGAP,
        SQ_SREAD,
        SQ_FIN
    } seq_e;

    typedef struct packed {
        logic [31:0] id;
        logic [7:0]  stat;
        logic        ok;
        logic        tmo;
    } result_t;

    localparam logic [7:0] OPC_RESET  = 8'hFF;
    localparam logic [7:0] OPC_ID     = 8'h90;
    localparam logic [7:0] OPC_STATUS = 8'h70;
    localparam logic [7:0] OPC_ERS1   = 8'h60;
    localparam logic [7:0] OPC_ERS2   = 8'hD0;

    function automatic logic [7:0] first_cmd(input op_e o);
        case (o)
            OP_RESET:  return OPC_RESET;
            OP_READID: return OPC_ID;
            OP_STATUS: return OPC_STATUS;
            default:   return OPC_ERS1;
        endcase
    endfunction

    function automatic logic [7:0] row_byte(input logic [23:0] row, input logic [1:0] idx);
        case (idx)
            2'd0:    return row[7:0];
            2'd1:    return row[15:8];
            default: return row[23:16];
        endcase
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int WE_LO   = 2,
    parameter int WE_HI   = 2,
    parameter int RE_LO   = 2,
    parameter int RE_HI   = 2,
    parameter int GAP_CLK = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  bus_kind_e kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic      ack,
    output logic [7:0] rbyte,
    output logic      we_n,
    output logic      re_n,
    output logic      cle,
    output logic      ale,
    output logic      io_oe,
    output logic [7:0] io_out
);
    localparam int M1   = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int M2   = (RE_LO > RE_HI) ? RE_LO : RE_HI;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXL = (M3 > GAP_CLK) ? M3 : GAP_CLK;
    localparam int CW   = $clog2(MAXL + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;

    phase_e      ph;
    bus_kind_e   kind_q;
    logic [7:0]  byte_q;
    logic [CW-1:0] cnt;

    function automatic int lo_len(input bus_kind_e k);
        case (k)
            BC_CMD, BC_ADDR: return WE_LO;
            BC_READ:         return RE_LO;
            default:         return GAP_CLK;
        endcase
    endfunction

    function automatic int hi_len(input bus_kind_e k);
        case (k)
            BC_CMD, BC_ADDR: return WE_HI;
            BC_READ:         return RE_HI;
            default:         return 1;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            kind_q <= BC_GAP;
            byte_q <= '0;
            cnt    <= '0;
            ack    <= 1'b0;
            rbyte  <= '0;
        end else begin
            ack <= 1'b0;
            case (ph)
                PH_IDLE: if (go) begin
                    ph     <= PH_LO;
                    kind_q <= kind;
                    byte_q <= wbyte;
                    cnt    <= CW'(lo_len(kind) - 1);
                end
                PH_LO: if (cnt == '0) begin
                    ph  <= PH_HI;
                    cnt <= CW'(hi_len(kind_q) - 1);
                    if (kind_q == BC_READ) rbyte <= io_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) begin
                    ph  <= PH_IDLE;
                    ack <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    logic active, is_wr;
    assign active = (ph != PH_IDLE);
    assign is_wr  = (kind_q == BC_CMD) || (kind_q == BC_ADDR);
    assign we_n   = !((ph == PH_LO) && is_wr);
    assign re_n   = !((ph == PH_LO) && (kind_q == BC_READ));
    assign cle    = active && (kind_q == BC_CMD);
    assign ale    = active && (kind_q == BC_ADDR);
    assign io_oe  = active && is_wr;
    assign io_out = io_oe ? byte_q : 8'h00;

endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
    parameter int T_WB   = 5,
    parameter int RB_MAX = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic rb_n,
    output logic ack,
    output logic tmo
);
    localparam int BIG = (T_WB > RB_MAX) ? T_WB : RB_MAX;
    localparam int TW  = $clog2(BIG + 1);

    typedef enum logic [1:0] {WT_IDLE, WT_HOLD, WT_POLL} wphase_e;

    wphase_e       ph;
    logic [TW-1:0] cnt;
    logic          rb_meta, rb_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_meta <= 1'b1;
            rb_sync <= 1'b1;
        end else begin
            rb_meta <= rb_n;
            rb_sync <= rb_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= WT_IDLE;
            cnt <= '0;
            ack <= 1'b0;
            tmo <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (ph)
                WT_IDLE: if (go) begin
                    ph  <= WT_HOLD;
                    cnt <= TW'(T_WB - 1);
                    tmo <= 1'b0;
                end
                WT_HOLD: if (cnt == '0) begin
                    ph <= WT_POLL;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (rb_sync) begin
                    ph  <= WT_IDLE;
                    ack <= 1'b1;
                end else if (cnt == TW'(RB_MAX - 1)) begin
                    ph  <= WT_IDLE;
                    ack <= 1'b1;
                    tmo <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int          BLK_W     = 13,
    parameter int          PAGE_BITS = 5,
    parameter int          WE_LO     = 2,
    parameter int          WE_HI     = 2,
    parameter int          RE_LO     = 2,
    parameter int          RE_HI     = 2,
    parameter int          T_GAP     = 4,
    parameter int          T_WB      = 5,
    parameter int          RB_MAX    = 200000,
    parameter logic [15:0] ID_EXPECT = 16'hEC76,
    parameter logic [7:0]  STAT_OK   = 8'hC0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [BLK_W-1:0] blk,
    output logic             done,
    output logic             ok,
    output logic             timeout_err,
    output logic [31:0]      id_word,
    output logic [7:0]       stat_byte,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    input  logic             nand_rb_n,
    input  logic [7:0]       nand_io_in,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe
);
    seq_e             st;
    op_e              op_q;
    logic [BLK_W-1:0] blk_q;
    logic [1:0]       idx;
    logic             launched;
    logic             done_q;
    result_t          res;

    logic      bus_go, bus_ack, rb_go, rb_ack, rb_tmo, is_bus, ok_calc;
    bus_kind_e bus_kind;
    logic [7:0] bus_byte, rbyte;
    logic [23:0] row;

    assign row = 24'(blk_q) << PAGE_BITS;

    always_comb begin
        is_bus = 1'b1;
        case (st)
            SQ_IDLE, SQ_RB, SQ_FIN: is_bus = 1'b0;
            default:                is_bus = 1'b1;
        endcase
    end

    always_comb begin
        bus_kind = BC_GAP;
        bus_byte = 8'h00;
        case (st)
            SQ_CMD1:  begin bus_kind = BC_CMD;  bus_byte = first_cmd(op_q); end
            SQ_ADDR:  begin
                bus_kind = BC_ADDR;
                bus_byte = (op_q == OP_ERASE) ? row_byte(row, idx) : 8'h00;
            end
            SQ_CMD2:  begin bus_kind = BC_CMD;  bus_byte = OPC_ERS2;   end
            SQ_SCMD:  begin bus_kind = BC_CMD;  bus_byte = OPC_STATUS; end
            SQ_READ, SQ_SREAD: bus_kind = BC_READ;
            default:  bus_kind = BC_GAP;
        endcase
    end

    assign bus_go = is_bus && !launched;
    assign rb_go  = (st == SQ_RB) && !launched;

    always_comb begin
        case (op_q)
            OP_RESET:  ok_calc = (res.stat == STAT_OK) && !res.tmo;
            OP_READID: ok_calc = (res.id[31:16] == ID_EXPECT);
            OP_STATUS: ok_calc = !res.stat[0];
            default:   ok_calc = !res.stat[0] && !res.tmo;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            op_q     <= OP_RESET;
            blk_q    <= '0;
            idx      <= '0;
            launched <= 1'b0;
            done_q   <= 1'b0;
            res      <= '0;
        end else begin
            done_q <= 1'b0;
            if (st == SQ_IDLE) begin
                if (start) begin
                    op_q     <= op_e'(op);
                    blk_q    <= blk;
                    idx      <= '0;
                    launched <= 1'b0;
                    res.tmo  <= 1'b0;
                    st       <= (op_e'(op) == OP_STATUS) ? SQ_SCMD : SQ_CMD1;
                end
            end else if (st == SQ_FIN) begin
                res.ok <= ok_calc;
                done_q <= 1'b1;
                st     <= SQ_IDLE;
            end else if (st == SQ_RB) begin
                if (!launched) begin
                    launched <= 1'b1;
                end else if (rb_ack) begin
                    launched <= 1'b0;
                    if (rb_tmo) begin
                        res.tmo <= 1'b1;
                        st      <= SQ_FIN;
                    end else begin
                        st <= SQ_CEOFF;
                    end
                end
            end else if (!launched) begin
                launched <= 1'b1;
            end else if (bus_ack) begin
                launched <= 1'b0;
                case (st)
                    SQ_CMD1: case (op_q)
                        OP_RESET:  st <= SQ_RB;
                        OP_STATUS: st <= SQ_FIN;
                        default:   st <= SQ_ADDR;
                    endcase
                    SQ_ADDR: begin
                        if (op_q == OP_READID) begin
                            st <= SQ_GAP;
                        end else if (idx == 2'd2) begin
                            idx <= '0;
                            st  <= SQ_CMD2;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    SQ_CMD2:  st <= SQ_RB;
                    SQ_GAP:   st <= SQ_READ;
                    SQ_READ: begin
                        res.id <= {res.id[23:0], rbyte};
                        if (idx == 2'd3) begin
                            idx <= '0;
                            st  <= SQ_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    SQ_CEOFF: st <= SQ_SCMD;
                    SQ_SCMD:  st <= SQ_SGAP;
                    SQ_SGAP:  st <= SQ_SREAD;
                    SQ_SREAD: begin
                        res.stat <= rbyte;
                        st       <= SQ_FIN;
                    end
                    default:  st <= SQ_IDLE;
                endcase
            end
        end
    end

    nand_bus_cycle #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI), .GAP_CLK(T_GAP)
    ) u_bus (
        .clk(clk), .rst(rst), .go(bus_go), .kind(bus_kind), .wbyte(bus_byte),
        .io_in(nand_io_in), .ack(bus_ack), .rbyte(rbyte),
        .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
        .io_oe(nand_io_oe), .io_out(nand_io_out)
    );

    nand_rb_wait #(.T_WB(T_WB), .RB_MAX(RB_MAX)) u_rb (
        .clk(clk), .rst(rst), .go(rb_go), .rb_n(nand_rb_n), .ack(rb_ack), .tmo(rb_tmo)
    );

    assign nand_ce_n   = (st == SQ_IDLE) || (st == SQ_CEOFF) || (st == SQ_FIN);
    assign done        = done_q;
    assign ok          = res.ok;
    assign timeout_err = res.tmo;
    assign id_word     = res.id;
    assign stat_byte   = res.stat;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic io_oe,
    input logic done,
    input logic ok,
    input logic tmo
);
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale)); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R7
    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n); // R7
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> ($stable(cle) && $stable(ale))); // R7
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !io_oe); // R8
    AST_DRIVE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> !ce_n); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_TMO_NOT_OK: assert property (@(posedge clk) disable iff (rst)
        (done && tmo) |-> !ok); // R6
endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk(clk), .rst(rst), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .io_oe(nand_io_oe),
    .done(done), .ok(ok), .tmo(timeout_err)
);

// File: tb/nand_seq_test.sv
module nand_seq_test;
    localparam int WE_LO  = 2;
    localparam int WE_HI  = 2;
    localparam int RE_LO  = 2;
    localparam int RE_HI  = 1;
    localparam int T_GAP  = 3;
    localparam int T_WB   = 3;
    localparam int RB_MAX = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [12:0] blk = '0;
    logic        done, ok, timeout_err;
    logic [31:0] id_word;
    logic [7:0]  stat_byte;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_rb_n, nand_io_oe;
    logic [7:0]  nand_io_in, nand_io_out;

    always #10 clk = ~clk;

    nand_seq #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
        .T_GAP(T_GAP), .T_WB(T_WB), .RB_MAX(RB_MAX)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .blk(blk),
        .done(done), .ok(ok), .timeout_err(timeout_err), .id_word(id_word),
        .stat_byte(stat_byte), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_rb_n(nand_rb_n), .nand_io_in(nand_io_in), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe)
    );

    typedef struct {
        bit          e_ok;
        bit          e_tmo;
        bit          cid;
        bit          cst;
        logic [31:0] id;
        logic [7:0]  st;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [8:0] log_q[$];
    logic [8:0] lq[$];

    // device model state
    logic [31:0] dev_id = 32'h0;
    logic [7:0]  dev_st = 8'hC0;
    int          busy_len = 30;
    int          busy_left = 0;
    int          rd_idx = 0;
    logic [7:0]  cur_cmd = 8'h00;
    logic [7:0]  prev_cmd = 8'h00;
    logic        we_d = 1'b1, re_d = 1'b1;
    int          we_low = 0, re_low = 0, ce_hi_seen = 0;

    int mon_chk = 0, mon_bad = 0, drv_chk = 0, drv_bad = 0, n_done = 0;

    function automatic logic [7:0] id_byte(input logic [31:0] w, input int k);
        case (k)
            0: return w[31:24];
            1: return w[23:16];
            2: return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    assign nand_rb_n  = (busy_left == 0);
    assign nand_io_in = (cur_cmd == 8'h90) ? id_byte(dev_id, rd_idx) : dev_st;

    // device model and result monitor share one process
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (busy_left > 0) busy_left--;
            if (nand_ce_n) ce_hi_seen++;
            if (!nand_we_n) we_low++;
            if (!nand_re_n) re_low++;
            if (!we_d && nand_we_n) begin
                mon_chk++;
                if (we_low != WE_LO) begin
                    mon_bad++;
                    $display("FAIL R7 WE low width: got %0d expected %0d", we_low, WE_LO);
                end
                we_low = 0;
                if (nand_cle) begin
                    log_q.push_back({1'b0, nand_io_out});
                    if (nand_io_out == 8'h70 && (cur_cmd == 8'hD0 || cur_cmd == 8'hFF)) begin
                        mon_chk++;
                        if (busy_left != 0 || ce_hi_seen < T_GAP) begin
                            mon_bad++;
                            $display("FAIL R5 status after busy: got busy=%0d ce_high=%0d expected busy=0 ce_high>=%0d",
                                     busy_left, ce_hi_seen, T_GAP);
                        end
                    end
                    prev_cmd = cur_cmd;
                    cur_cmd  = nand_io_out;
                    rd_idx   = 0;
                    ce_hi_seen = 0;
                    if (nand_io_out == 8'hFF || nand_io_out == 8'hD0) busy_left = busy_len;
                end else if (nand_ale) begin
                    log_q.push_back({1'b1, nand_io_out});
                end
            end
            if (!re_d && nand_re_n) begin
                mon_chk++;
                if (re_low != RE_LO) begin
                    mon_bad++;
                    $display("FAIL R7 RE low width: got %0d expected %0d", re_low, RE_LO);
                end
                re_low = 0;
                rd_idx++;
            end
            we_d = nand_we_n;
            re_d = nand_re_n;

            if (done) begin
                n_done++;
                mon_chk++;
                if (exp_q.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R9 done pulse: got unexpected done expected none");
                end else begin
                    e = exp_q.pop_front();
                    if (ok !== e.e_ok) begin
                        mon_bad++;
                        $display("FAIL %s ok: got %b expected %b", e.tag, ok, e.e_ok);
                    end
                    mon_chk++;
                    if (timeout_err !== e.e_tmo) begin
                        mon_bad++;
                        $display("FAIL %s timeout: got %b expected %b", e.tag, timeout_err, e.e_tmo);
                    end
                    if (e.cid) begin
                        mon_chk++;
                        if (id_word !== e.id) begin
                            mon_bad++;
                            $display("FAIL %s id: got %h expected %h", e.tag, id_word, e.id);
                        end
                    end
                    if (e.cst) begin
                        mon_chk++;
                        if (stat_byte !== e.st) begin
                            mon_bad++;
                            $display("FAIL %s status: got %h expected %h", e.tag, stat_byte, e.st);
                        end
                    end
                end
            end
        end
    end

    task automatic run_op(input logic [1:0] o, input logic [12:0] b,
                          input bit e_ok, input bit e_tmo,
                          input bit cid, input logic [31:0] eid,
                          input bit cst, input logic [7:0] est,
                          input string tag, input bit poke);
        exp_t e;
        e.e_ok = e_ok; e.e_tmo = e_tmo; e.cid = cid; e.id = eid;
        e.cst = cst; e.st = est; e.tag = tag;
        exp_q.push_back(e);
        log_q.delete();
        op = o; blk = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (12) @(negedge clk);
            op = 2'd1; blk = 13'h0AAA; start = 1'b1;   // R9 ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (done !== 1'b1);
    endtask

    task automatic check_log(input string tag);
        bit bad = 1'b0;
        drv_chk++;
        if (log_q.size() != lq.size()) bad = 1'b1;
        else foreach (lq[i]) if (log_q[i] !== lq[i]) bad = 1'b1;
        if (bad) begin
            drv_bad++;
            $display("FAIL %s bus log: got %p expected %p", tag, log_q, lq);
        end
    endtask

    task automatic run_all();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        drv_chk++;
        if (done !== 1'b0 || nand_ce_n !== 1'b1 || nand_we_n !== 1'b1 ||
            nand_re_n !== 1'b1 || nand_io_oe !== 1'b0) begin
            drv_bad++;
            $display("FAIL R9 reset state: got done=%b ce=%b we=%b re=%b oe=%b expected 0 1 1 1 0",
                     done, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe);
        end

        dev_st = 8'hC0;
        run_op(2'd0, '0, 1, 0, 0, '0, 1, 8'hC0, "R1 reset good", 0);
        lq = '{9'h0FF, 9'h070}; check_log("R1 reset");

        dev_id = 32'hEC76A5C0;
        run_op(2'd1, '0, 1, 0, 1, 32'hEC76A5C0, 0, '0, "R2 id a", 0);
        lq = '{9'h090, 9'h100}; check_log("R2 id");
        dev_id = 32'hEC765A3F;
        run_op(2'd1, '0, 1, 0, 1, 32'hEC765A3F, 0, '0, "R2 id low ignored", 0);
        dev_id = 32'h98DA0011;
        run_op(2'd1, '0, 0, 0, 1, 32'h98DA0011, 0, '0, "R2 id mismatch", 0);

        dev_st = 8'hC0;
        run_op(2'd2, '0, 1, 0, 0, '0, 1, 8'hC0, "R3 status pass", 0);
        lq = '{9'h070}; check_log("R3 status");
        dev_st = 8'hC1;
        run_op(2'd2, '0, 0, 0, 0, '0, 1, 8'hC1, "R3 status fail", 0);
        dev_st = 8'hE0;
        run_op(2'd0, '0, 0, 0, 0, '0, 1, 8'hE0, "R1 reset bad status", 0);

        dev_st = 8'hC0;
        run_op(2'd3, 13'h1ABC, 1, 0, 0, '0, 1, 8'hC0, "R5 erase pass", 0);
        lq = '{9'h060, 9'h180, 9'h157, 9'h103, 9'h0D0, 9'h070}; check_log("R4 erase 1ABC");
        dev_st = 8'hC1;
        run_op(2'd3, 13'h1FFF, 0, 0, 0, '0, 1, 8'hC1, "R5 erase fail", 0);
        lq = '{9'h060, 9'h1E0, 9'h1FF, 9'h103, 9'h0D0, 9'h070}; check_log("R4 erase 1FFF");
        dev_st = 8'hC0;
        run_op(2'd3, 13'h0000, 1, 0, 0, '0, 1, 8'hC0, "R5 erase block 0", 0);
        lq = '{9'h060, 9'h100, 9'h100, 9'h100, 9'h0D0, 9'h070}; check_log("R4 erase 0");

        run_op(2'd3, 13'h0005, 1, 0, 0, '0, 1, 8'hC0, "R9 erase with stray start", 1);
        lq = '{9'h060, 9'h1A0, 9'h100, 9'h100, 9'h0D0, 9'h070}; check_log("R9 stray start ignored");
        repeat (60) @(negedge clk);

        busy_len = 400;
        run_op(2'd3, 13'h0002, 0, 1, 0, '0, 0, '0, "R6 erase timeout", 0);
        lq = '{9'h060, 9'h140, 9'h100, 9'h100, 9'h0D0}; check_log("R6 no status after timeout");
        repeat (450) @(negedge clk);
        busy_len = 30;
        run_op(2'd2, '0, 1, 0, 0, '0, 1, 8'hC0, "R6 timeout flag cleared", 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            drv_chk++;
            drv_bad++;
            $display("FAIL watchdog: got hang expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", mon_chk + drv_chk, mon_bad + drv_bad);
        $finish;
    end

endmodule